// File: doc/BRIEF.md
# External Bus Cycle Master with Acknowledge Handshake

This block turns single read and write requests from inside the chip into cycles on an external memory and peripheral bus. A request is taken only while the block is idle. The block then steps through six fixed phases, S0 to S5, which mark out the cycle. It presents the address, the transfer size and the direction, and marks the cycle with a transfer-in-progress flag and a one-clock start strobe. On a write it drives the data bus. It then waits until the addressed device pulls the acknowledge line low.

The device controls the length of each cycle. Each clock in which the acknowledge is seen high in the wait phase adds one wait state. Read data is captured on the clock edge at which the acknowledge is seen low. It is returned to the requester with a one-clock done pulse. After the acknowledge there is a completion phase and a turnaround phase. These give the device time to release the data bus before the master can drive it again.

Top module: `xbus_master`

## Requirements
- R1: While reset is held and in the first clock after it is released, the start strobe and the in-progress flag are high (inactive), the data output enable is low and done is low.
- R2: An accepted request makes the start strobe go low for exactly one clock, the first clock after acceptance. The in-progress flag goes low in that same clock and stays low through the clock in which the acknowledge is sampled low.
- R3: Address, size and direction (busRnw: 1 = read, 0 = write) are presented from the start-strobe clock and do not change while the in-progress flag is low. Size is copied unchanged from the request: 00 longword, 01 byte, 10 word, 11 line.
- R4: The acknowledge is sampled only in the wait phase. A cycle with N clocks of acknowledge sampled high keeps the in-progress flag low for 3 + N clocks.
- R5: Read data is captured from the bus at the rising edge where the acknowledge is sampled low. It appears on rspRdata together with done.
- R6: The data output enable is high only for writes. It rises in the second clock of the cycle, holds the write data stable until the acknowledge, and is low in the clock after the acknowledge is sampled.
- R7: Done is high for exactly one clock per bus cycle, in the clock after the acknowledge is sampled, with the in-progress flag already high.
- R8: A request raised while a cycle is in progress is ignored and starts no further start strobe.
- R9: With a request held waiting at done, the next start strobe comes 3 clocks after done. A following write enables its data output 4 clocks after the done of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present; taken only when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Request address |
| reqSize | input | 2 | Transfer size code |
| reqWdata | input | 32 | Write data |
| rspRdata | output | 32 | Captured read data |
| rspDone | output | 1 | One-clock completion pulse |
| busAddr | output | 32 | External address |
| busSize | output | 2 | External size code |
| busRnw | output | 1 | Direction, 1 = read |
| busTsN | output | 1 | Start strobe, active low |
| busTipN | output | 1 | Transfer in progress, active low |
| busDataOut | output | 32 | Write data to the bus |
| busDataOe | output | 1 | Enable for busDataOut |
| busDataIn | input | 32 | Read data from the bus |
| busTaN | input | 1 | Device acknowledge, active low |

## Verification
The assertions assume that the device pulls the acknowledge low only while the block is in its wait phase. They also assume the device lets the acknowledge go high again in the clock after it has been sampled. If the acknowledge were low during the start or drive clock, the completion property would not hold. The bench models the device so that it stays inside this limit. The device counts clocks from the start strobe, asserts the acknowledge only after the two fixed phases plus the chosen wait count, and releases it as soon as the in-progress flag rises.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  // Cycle phases: S0 idle/accept, S1 start strobe, S2 data drive,
  // S3 wait and sample acknowledge, S4 completion, S5 bus turnaround.
  typedef enum logic [2:0] {
    PH_S0 = 3'd0,
    PH_S1 = 3'd1,
    PH_S2 = 3'd2,
    PH_S3 = 3'd3,
    PH_S4 = 3'd4,
    PH_S5 = 3'd5
  } phase_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;     // latch a new request
    logic capture;  // take read data from the bus
  } dp_ctl_t;

endpackage

// File: rtl/xbus_ctl.sv
module xbus_ctl
  import xbus_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    busRnw,
  input  logic    busTaN,
  output dp_ctl_t dpCtl,
  output logic    busTsN,
  output logic    busTipN,
  output logic    busDataOe,
  output logic    rspDone
);

  phase_e phaseQ, phaseD;
  logic   taSeen;

  assign taSeen = (phaseQ == PH_S3) && !busTaN;

  always_comb begin
    phaseD = phaseQ;
    unique case (phaseQ)
      PH_S0: if (reqValid) phaseD = PH_S1;
      PH_S1: phaseD = PH_S2;
      PH_S2: phaseD = PH_S3;
      PH_S3: if (taSeen) phaseD = PH_S4;
      PH_S4: phaseD = PH_S5;
      PH_S5: phaseD = PH_S0;
      default: phaseD = PH_S0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= PH_S0;
    else       phaseQ <= phaseD;
  end

  always_comb begin
    dpCtl.load    = (phaseQ == PH_S0) && reqValid;
    dpCtl.capture = taSeen && busRnw;
  end

  assign busTsN    = (phaseQ != PH_S1);
  assign busTipN   = !((phaseQ == PH_S1) || (phaseQ == PH_S2) || (phaseQ == PH_S3));
  assign busDataOe = !busRnw && ((phaseQ == PH_S2) || (phaseQ == PH_S3));
  assign rspDone   = (phaseQ == PH_S4);

endmodule

// File: rtl/xbus_dp.sv
module xbus_dp
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           dpCtl,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [SIZE_W-1:0] busSize,
  output logic              busRnw,
  output logic [DATA_W-1:0] busDataOut,
  output logic [DATA_W-1:0] rspRdata
);

  // Request fields held for the whole cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAddr    <= '0;
      busSize    <= '0;
      busRnw     <= 1'b1;
      busDataOut <= '0;
    end else if (dpCtl.load) begin
      busAddr    <= reqAddr;
      busSize    <= reqSize;
      busRnw     <= !reqWrite;
      busDataOut <= reqWdata;
    end
  end

  // Read data register, loaded on the acknowledge edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rspRdata <= '0;
    else if (dpCtl.capture) rspRdata <= busDataIn;
  end

endmodule

// File: rtl/xbus_master.sv
module xbus_master
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspDone,
  output logic [ADDR_W-1:0] busAddr,
  output logic [SIZE_W-1:0] busSize,
  output logic              busRnw,
  output logic              busTsN,
  output logic              busTipN,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic              busTaN
);

  dp_ctl_t dpCtl;

  xbus_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .busRnw    (busRnw),
    .busTaN    (busTaN),
    .dpCtl     (dpCtl),
    .busTsN    (busTsN),
    .busTipN   (busTipN),
    .busDataOe (busDataOe),
    .rspDone   (rspDone)
  );

  xbus_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SIZE_W (SIZE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dpCtl      (dpCtl),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .reqSize    (reqSize),
    .reqWdata   (reqWdata),
    .busDataIn  (busDataIn),
    .busAddr    (busAddr),
    .busSize    (busSize),
    .busRnw     (busRnw),
    .busDataOut (busDataOut),
    .rspRdata   (rspRdata)
  );

endmodule

// File: rtl/xbus_master_chk.sv
module xbus_master_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              rspDone,
  input logic [ADDR_W-1:0] busAddr,
  input logic [SIZE_W-1:0] busSize,
  input logic              busRnw,
  input logic              busTsN,
  input logic              busTipN,
  input logic [DATA_W-1:0] busDataOut,
  input logic              busDataOe,
  input logic              busTaN
);

  // R1: reset leaves the bus idle
  a_r1_reset_idle: assert property (@(posedge clk)
    !rstN |=> (busTsN && busTipN && !busDataOe && !rspDone));

  // R2: start strobe lasts one clock and sits inside the in-progress window
  a_r2_ts_single: assert property (@(posedge clk) disable iff (!rstN)
    !busTsN |=> busTsN);
  a_r2_ts_in_tip: assert property (@(posedge clk) disable iff (!rstN)
    !busTsN |-> !busTipN);

  // R3: address, size and direction hold while the cycle runs
  a_r3_hold_fields: assert property (@(posedge clk) disable iff (!rstN)
    (!busTipN && busTsN) |-> ($stable(busAddr) && $stable(busSize) && $stable(busRnw)));

  // R6: data enable only on writes, write data steady while driven
  a_r6_oe_write_only: assert property (@(posedge clk) disable iff (!rstN)
    busDataOe |-> (!busRnw && !busTipN));
  a_r6_oe_after_ts: assert property (@(posedge clk) disable iff (!rstN)
    !busTsN |=> (busDataOe == !busRnw));
  a_r6_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busDataOe && $past(busDataOe)) |-> $stable(busDataOut));

  // R4/R7: acknowledge ends the cycle, done follows with output enable off
  a_r7_ack_done: assert property (@(posedge clk) disable iff (!rstN)
    (!busTipN && busTsN && !busTaN && !busDataOe == busRnw) |=>
      (busTipN && !busDataOe && rspDone));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);
  a_r7_done_idle_bus: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> busTipN);

  // R8: no new start strobe directly out of a running cycle
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    !busTipN |=> busTsN);

endmodule

bind xbus_master xbus_master_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .SIZE_W (SIZE_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rspDone    (rspDone),
  .busAddr    (busAddr),
  .busSize    (busSize),
  .busRnw     (busRnw),
  .busTsN     (busTsN),
  .busTipN    (busTipN),
  .busDataOut (busDataOut),
  .busDataOe  (busDataOe),
  .busTaN     (busTaN)
);

// File: tb/xbus_master_tb.sv
module xbus_master_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic [1:0]  reqSize = '0;
  logic [31:0] rspRdata, busAddr, busDataOut;
  logic [31:0] busDataIn = '0;
  logic [1:0]  busSize;
  logic        rspDone, busRnw, busTsN, busTipN, busDataOe;
  logic        busTaN = 1'b1;

  always #10 clk = ~clk;

  xbus_master u_dut (.*);

  int nChk = 0, nFail = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  int          devWaits = 0;
  logic [31:0] devRdata = '0;
  bit          active = 0;
  int          cnt, tipLow, tsLow, tsCount = 0, stableErr = 0, oeReadErr = 0;
  logic [31:0] capAddr, seenWdata, seenRdata, s2Wdata;
  logic [1:0]  capSize;
  logic        capRnw, oeAtS1, oeAtS2, seenOe, oeAfter, doneAtEnd;

  always @(negedge clk) begin
    if (!busTsN) begin
      active = 1; cnt = 0; tipLow = 1; tsLow = 1; tsCount++;
      capAddr = busAddr; capSize = busSize; capRnw = busRnw; oeAtS1 = busDataOe;
    end else if (active) begin
      if (!busTipN) begin
        tipLow++; cnt++;
        if (busAddr != capAddr || busSize != capSize || busRnw != capRnw) stableErr++;
        if (busRnw && busDataOe) oeReadErr++;
        if (cnt == 1) begin oeAtS2 = busDataOe; s2Wdata = busDataOut; end
        else if (busDataOe && busDataOut != s2Wdata) stableErr++;
        if (cnt == 2 + devWaits) begin
          busTaN = 1'b0; busDataIn = devRdata;
          seenWdata = busDataOut; seenOe = busDataOe;
        end
      end else begin
        busTaN = 1'b1; busDataIn = '0; active = 0;
        oeAfter = busDataOe; doneAtEnd = rspDone; seenRdata = rspRdata;
      end
    end
  end

  int doneCount = 0, doneRunErr = 0;
  logic prevDone = 1'b0;
  always @(negedge clk) begin
    if (rspDone) begin doneCount++; if (prevDone) doneRunErr++; end
    prevDone = rspDone;
  end

  // ---------------- tasks ----------------
  task automatic issue(input bit wr, input logic [31:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, input int waits, input logic [31:0] rd);
    @(negedge clk);
    devWaits = waits; devRdata = rd;
    reqValid = 1; reqWrite = wr; reqAddr = a; reqSize = sz; reqWdata = wd;
    @(negedge clk);
    reqValid = 0;
    do @(negedge clk); while (!rspDone);
    @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(busTsN && busTipN && !busDataOe && !rspDone, "R1 idle in reset",
        {busTsN, busTipN, busDataOe, rspDone}, 4'b1100);
    rstN = 1;
    @(negedge clk);
    chk(busTsN && busTipN && !busDataOe && !rspDone, "R1 idle after reset",
        {busTsN, busTipN, busDataOe, rspDone}, 4'b1100);
  endtask

  task automatic testRead(input logic [31:0] a, input logic [1:0] sz, input int waits,
                          input logic [31:0] rd);
    int d0;
    d0 = doneCount;
    issue(0, a, sz, '0, waits, rd);
    chk(seenRdata == rd, "R5 read data", seenRdata, rd);
    chk(tipLow == 3 + waits, "R4 tip length", tipLow, 3 + waits);
    chk(tsLow == 1, "R2 strobe one clock", tsLow, 1);
    chk(capAddr == a && capSize == sz && capRnw == 1, "R3 read fields",
        {capAddr, capSize, capRnw}, {a, sz, 1'b1});
    chk(stableErr == 0, "R3 fields stable", stableErr, 0);
    chk(oeReadErr == 0 && !oeAtS2, "R6 no enable on read", oeReadErr, 0);
    chk(doneAtEnd && doneCount == d0 + 1 && doneRunErr == 0, "R7 done pulse",
        doneCount - d0, 1);
  endtask

  task automatic testWrite(input logic [31:0] a, input logic [1:0] sz, input int waits,
                           input logic [31:0] wd);
    issue(1, a, sz, wd, waits, 32'h0);
    chk(capRnw == 0 && capAddr == a && capSize == sz, "R3 write fields",
        {capAddr, capSize, capRnw}, {a, sz, 1'b0});
    chk(seenWdata == wd && seenOe, "R6 write data at ack", seenWdata, wd);
    chk(!oeAtS1 && oeAtS2, "R6 enable from second clock", {oeAtS1, oeAtS2}, 2'b01);
    chk(!oeAfter, "R6 enable dropped after ack", oeAfter, 0);
    chk(tipLow == 3 + waits, "R4 write tip length", tipLow, 3 + waits);
    chk(stableErr == 0, "R3 write fields stable", stableErr, 0);
  endtask

  task automatic testBusyIgnore();
    int t0;
    t0 = tsCount;
    @(negedge clk);
    devWaits = 4; devRdata = 32'h600D_F00D;
    reqValid = 1; reqWrite = 0; reqAddr = 32'h100; reqSize = 2'b00;
    @(negedge clk); reqValid = 0;
    @(negedge clk); reqValid = 1; reqWrite = 1; reqAddr = 32'hBAD0;
    @(negedge clk); reqValid = 0;
    do @(negedge clk); while (!rspDone);
    repeat (6) @(negedge clk);
    chk(tsCount == t0 + 1, "R8 busy request ignored", tsCount - t0, 1);
    chk(capAddr == 32'h100, "R8 address kept", capAddr, 32'h100);
  endtask

  task automatic testBackToBack();
    int gap, tsGap, oeGap;
    @(negedge clk);
    devWaits = 1; devRdata = 32'hCAFE_0001;
    reqValid = 1; reqWrite = 0; reqAddr = 32'h2000; reqSize = 2'b10;
    @(negedge clk); reqValid = 0;
    do @(negedge clk); while (!rspDone);
    chk(rspRdata == 32'hCAFE_0001, "R5 data with done", rspRdata, 32'hCAFE_0001);
    devWaits = 0;
    reqValid = 1; reqWrite = 1; reqAddr = 32'h2004; reqWdata = 32'h1234_5678;
    gap = 0; tsGap = -1; oeGap = -1;
    while (oeGap < 0 && gap < 20) begin
      @(negedge clk); gap++;
      if (!busTsN) begin tsGap = gap; reqValid = 0; end
      if (busDataOe) oeGap = gap;
    end
    chk(tsGap == 3, "R9 next strobe after done", tsGap, 3);
    chk(oeGap == 4, "R9 write enable after read", oeGap, 4);
    do @(negedge clk); while (!rspDone);
    @(negedge clk);
    chk(seenWdata == 32'h1234_5678, "R6 back-to-back write data", seenWdata, 32'h1234_5678);
  endtask

  initial begin
    testReset();
    testRead(32'h0000_1000, 2'b00, 0, 32'hDEAD_BEEF);
    testRead(32'h0000_2002, 2'b10, 3, 32'h0BAD_CAFE);
    testRead(32'hFFFF_FFF1, 2'b01, 7, 32'hA5A5_5A5A);
    testWrite(32'h0000_3000, 2'b00, 0, 32'h1111_2222);
    testWrite(32'h8000_0010, 2'b11, 2, 32'hFEDC_BA98);
    testBusyIgnore();
    testBackToBack();
    testRead(32'h0000_0004, 2'b01, 1, 32'h0000_00FF);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #(20 * 20000);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule